// File: doc/BRIEF.md
# Power mode and clock-division controller

This block decides which power mode a small processor system is in and how fast its logic is clocked. Six states are tracked: reset (`PM_RESET`), full rate (`PM_FULL`), divided rate (`PM_DIV`), sleep (`PM_SLEEP`), software standby (`PM_SWSTBY`) and hardware standby (`PM_HWSTBY`). Three one-cycle clock enables come out of the block, one each for the CPU, the bus masters and the peripherals. Each enable is taken from a free-running divider counter, so it pulses once every 2^ratio cycles.

Software writes a ratio code through `clk_sel`/`clk_sel_wr`. The code waits in a pending register and takes effect only on a `bus_end` pulse. A `sleep_req` strobe, with `stby_sel` choosing the depth, puts the block into sleep or software standby. A wake event returns it to the mode it was in before, and the active division ratio is kept. The hardware-standby pin overrides everything else. The reset pin and the watchdog overflow force the reset state and clear the division.

The block has these transitions:

- RESET→FULL: when reset is released.
- FULL↔DIV: on `bus_end`, when a pending code is applied.
- FULL/DIV→SLEEP or SWSTBY: on `sleep_req`.
- SLEEP→FULL/DIV: on any interrupt.
- SWSTBY→FULL/DIV: on an external interrupt.
- any→HWSTBY: when the hardware-standby pin goes low.
- HWSTBY→RESET: when that pin is released.
- any→RESET: on the reset pin or a watchdog overflow.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `res_n` is low, or in the cycle after `wdt_ovf` is high, `mode_o` is 0 (reset), `ratio_o` is 0, any pending code is discarded and all enables are low. One cycle after release, `mode_o` is 1 (full rate).
- R2: A `clk_sel_wr` write of code 1..5 is held pending. `ratio_o` and `mode_o` do not change until a `bus_end` pulse arrives in mode 1 or 2. After that edge, `ratio_o` equals the code and `mode_o` is 2 (divided).
- R3: A pending code of 0, applied by `bus_end`, gives `ratio_o` = 0 and `mode_o` = 1.
- R4: Writes of codes 6 and 7 are ignored. They neither replace the pending code nor change `ratio_o`.
- R5: In modes 1 and 2, each enable pulses exactly once every 2^`ratio_o` cycles. Over any 64 consecutive cycles it is high 64>>`ratio_o` times, and with ratio 0 it is high every cycle.
- R6: A `sleep_req` with `stby_sel`=0 in mode 1 or 2 leads to `mode_o`=3 (sleep). In sleep, `cpu_clk_en` stays low while `bus_clk_en` and `per_clk_en` keep pulsing at the current ratio.
- R7: In sleep, `irq_int` or `irq_ext` returns the block to mode 1 or 2, according to the preserved `ratio_o`.
- R8: A `sleep_req` with `stby_sel`=1 in mode 1 or 2 leads to `mode_o`=4 (software standby), and all enables stay low there.
- R9: In software standby, `irq_int` has no effect. `irq_ext` returns the block to mode 1 or 2 with `ratio_o` preserved.
- R10: `hstby_n` low moves the block to `mode_o`=5 (hardware standby) from any mode, even while `res_n` is low. All enables stay low there and interrupts are ignored.
- R11: After `hstby_n` is released, the block spends one cycle in mode 0 and then enters mode 1 with `ratio_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| res_n | input | 1 | Reset pin, active low, sampled on the clock |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| hstby_n | input | 1 | Hardware standby pin, active low |
| clk_sel | input | 3 | Division code (0 full, n gives 1/2^n, 6 and 7 reserved) |
| clk_sel_wr | input | 1 | Write strobe for `clk_sel` |
| stby_sel | input | 1 | Depth of the next sleep: 0 sleep, 1 software standby |
| sleep_req | input | 1 | Sleep instruction strobe |
| bus_end | input | 1 | End of the current bus cycle |
| irq_int | input | 1 | Internal interrupt request |
| irq_ext | input | 1 | External interrupt request |
| mode_o | output | 3 | Current mode, encoded 0..5 as listed above |
| ratio_o | output | 3 | Active division code |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| bus_clk_en | output | 1 | Bus-master clock enable pulse |
| per_clk_en | output | 1 | Peripheral clock enable pulse |

## Verification
The bench uses the default parameters: a 3-bit code field, a largest code of 5 and a 5-bit divider counter. With these values the whole code space is small. For every starting ratio 0..5, the bench writes each of the eight codes and counts enable pulses over a 64-cycle window. That window is exactly two periods of the slowest division. Sleep and both standby modes are entered at every ratio, and hardware standby is entered from each of the other five modes.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        PM_RESET  = 3'd0,
        PM_FULL   = 3'd1,
        PM_DIV    = 3'd2,
        PM_SLEEP  = 3'd3,
        PM_SWSTBY = 3'd4,
        PM_HWSTBY = 3'd5
    } pm_state_t;

endpackage

// File: rtl/pwr_ratio_latch.sv
module pwr_ratio_latch #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_val,
    input  logic             apply,
    output logic [SEL_W-1:0] ratio,
    output logic [SEL_W-1:0] ratio_nxt
);

    localparam logic [SEL_W-1:0] LIMIT = SEL_W'(MAX_SEL);

    logic [SEL_W-1:0] pend_val;
    logic             pend_vld;
    logic             wr_ok;

    // codes above LIMIT are reserved and dropped here
    assign wr_ok     = wr_en && (wr_val <= LIMIT);
    assign ratio_nxt = (apply && pend_vld) ? pend_val : ratio;

    always_ff @(posedge clk) begin
        if (clear) begin
            ratio    <= '0;
            pend_val <= '0;
            pend_vld <= 1'b0;
        end else begin
            if (apply && pend_vld) begin
                ratio    <= pend_val;
                pend_vld <= 1'b0;
            end
            if (wr_ok) begin
                pend_val <= wr_val;
                pend_vld <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
    parameter int SEL_W = 3,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             clear,
    input  logic [SEL_W-1:0] ratio,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] msk;

    // bit g of the mask is set when the ratio reaches past it
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign msk[g] = (g < int'(ratio));
    end

    always_ff @(posedge clk) begin
        if (clear) cnt <= '0;
        else       cnt <= cnt + 1'b1;
    end

    assign tick = ((cnt & msk) == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             res_n,
    input  logic             wdt_ovf,
    input  logic             hstby_n,
    input  logic             sleep_req,
    input  logic             stby_sel,
    input  logic             irq_int,
    input  logic             irq_ext,
    input  logic [SEL_W-1:0] ratio_nxt,
    input  logic             tick,
    output pm_state_t        state,
    output logic             running,
    output logic             clear,
    output logic             cpu_en,
    output logic             bus_en,
    output logic             per_en
);

    pm_state_t nxt;
    pm_state_t run_pick;

    assign run_pick = (ratio_nxt != '0) ? PM_DIV : PM_FULL;
    assign running  = (state == PM_FULL) || (state == PM_DIV);
    assign clear    = !hstby_n || !res_n || wdt_ovf
                      || (state == PM_HWSTBY) || (state == PM_RESET);

    always_comb begin
        nxt = state;
        if (!hstby_n) begin
            nxt = PM_HWSTBY;
        end else if (state == PM_HWSTBY) begin
            nxt = PM_RESET;
        end else if (!res_n || wdt_ovf) begin
            nxt = PM_RESET;
        end else begin
            unique case (state)
                PM_RESET:  nxt = PM_FULL;
                PM_FULL,
                PM_DIV: begin
                    if (sleep_req) nxt = stby_sel ? PM_SWSTBY : PM_SLEEP;
                    else           nxt = run_pick;
                end
                PM_SLEEP:  if (irq_int || irq_ext) nxt = run_pick;
                PM_SWSTBY: if (irq_ext) nxt = run_pick;
                PM_HWSTBY: nxt = PM_RESET;
                default:   nxt = PM_RESET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        state <= nxt;
    end

    // enable outputs
    always_comb begin
        cpu_en = 1'b0;
        bus_en = 1'b0;
        per_en = 1'b0;
        unique case (state)
            PM_FULL,
            PM_DIV: begin
                cpu_en = tick;
                bus_en = tick;
                per_en = tick;
            end
            PM_SLEEP: begin
                bus_en = tick;
                per_en = tick;
            end
            default: ;
        endcase
    end

    p_hwstby_entry_r10: assert property (@(posedge clk) disable iff (!res_n)
        !hstby_n |=> state == PM_HWSTBY);

    p_hwstby_exit_r11: assert property (@(posedge clk) disable iff (!res_n)
        (state == PM_HWSTBY && hstby_n) |=> state == PM_RESET);

    p_swstby_hold_r9: assert property (@(posedge clk) disable iff (!res_n)
        (state == PM_SWSTBY && !irq_ext && hstby_n && !wdt_ovf)
        |=> state == PM_SWSTBY);

    p_sleep_wake_r7: assert property (@(posedge clk) disable iff (!res_n)
        (state == PM_SLEEP && (irq_int || irq_ext) && hstby_n && !wdt_ovf)
        |=> (state == PM_FULL || state == PM_DIV));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             res_n,
    input  logic             wdt_ovf,
    input  logic             hstby_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             clk_sel_wr,
    input  logic             stby_sel,
    input  logic             sleep_req,
    input  logic             bus_end,
    input  logic             irq_int,
    input  logic             irq_ext,
    output logic [2:0]       mode_o,
    output logic [SEL_W-1:0] ratio_o,
    output logic             cpu_clk_en,
    output logic             bus_clk_en,
    output logic             per_clk_en
);

    localparam int CNT_W = MAX_SEL;

    pm_state_t        state;
    logic             running;
    logic             clear;
    logic             tick;
    logic [SEL_W-1:0] ratio;
    logic [SEL_W-1:0] ratio_nxt;
    logic             apply;

    assign apply = bus_end && running && !clear;

    pwr_ratio_latch #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_latch (
        .clk       (clk),
        .clear     (clear),
        .wr_en     (clk_sel_wr),
        .wr_val    (clk_sel),
        .apply     (apply),
        .ratio     (ratio),
        .ratio_nxt (ratio_nxt)
    );

    pwr_clk_div #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .clear (clear),
        .ratio (ratio),
        .tick  (tick)
    );

    pwr_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk       (clk),
        .res_n     (res_n),
        .wdt_ovf   (wdt_ovf),
        .hstby_n   (hstby_n),
        .sleep_req (sleep_req),
        .stby_sel  (stby_sel),
        .irq_int   (irq_int),
        .irq_ext   (irq_ext),
        .ratio_nxt (ratio_nxt),
        .tick      (tick),
        .state     (state),
        .running   (running),
        .clear     (clear),
        .cpu_en    (cpu_clk_en),
        .bus_en    (bus_clk_en),
        .per_en    (per_clk_en)
    );

    assign mode_o  = state;
    assign ratio_o = ratio;

    p_div_needs_ratio_r2: assert property (@(posedge clk) disable iff (!res_n)
        state == PM_DIV |-> ratio != '0);

    p_ratio_hold_r2: assert property (@(posedge clk) disable iff (!res_n)
        (!bus_end && hstby_n && !wdt_ovf) |=> $stable(ratio));

    p_wdt_clear_r1: assert property (@(posedge clk) disable iff (!res_n)
        (wdt_ovf && hstby_n) |=> (state == PM_RESET && ratio == '0));

    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!res_n)
        (state == PM_DIV && $stable(ratio) && per_clk_en)
        |=> (!per_clk_en || state == PM_FULL));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       res_n = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       hstby_n = 1'b1;
    logic [2:0] clk_sel = 3'd0;
    logic       clk_sel_wr = 1'b0;
    logic       stby_sel = 1'b0;
    logic       sleep_req = 1'b0;
    logic       bus_end = 1'b0;
    logic       irq_int = 1'b0;
    logic       irq_ext = 1'b0;
    logic [2:0] mode_o;
    logic [2:0] ratio_o;
    logic       cpu_clk_en, bus_clk_en, per_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;

    pwr_mode_ctrl u0 (
        .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .hstby_n(hstby_n),
        .clk_sel(clk_sel), .clk_sel_wr(clk_sel_wr), .stby_sel(stby_sel),
        .sleep_req(sleep_req), .bus_end(bus_end), .irq_int(irq_int),
        .irq_ext(irq_ext), .mode_o(mode_o), .ratio_o(ratio_o),
        .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > WD_LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", n_cyc, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int run_mode(input int r);
        return (r == 0) ? 1 : 2;
    endfunction

    task automatic do_reset();
        res_n = 1'b0;
        cyc();
        cyc();
        chk("R1 reset mode", mode_o, 0);
        chk("R1 reset ratio", ratio_o, 0);
        chk("R1 reset enables", {cpu_clk_en, bus_clk_en, per_clk_en}, 0);
        res_n = 1'b1;
        cyc();
        chk("R1 release mode", mode_o, 1);
    endtask

    task automatic wr_code(input int v);
        clk_sel = 3'(v);
        clk_sel_wr = 1'b1;
        cyc();
        clk_sel_wr = 1'b0;
    endtask

    task automatic end_bus();
        bus_end = 1'b1;
        cyc();
        bus_end = 1'b0;
    endtask

    task automatic set_ratio(input int v);
        wr_code(v);
        end_bus();
    endtask

    task automatic count64(output int c_cpu, output int c_bus, output int c_per);
        c_cpu = 0; c_bus = 0; c_per = 0;
        for (int i = 0; i < 64; i++) begin
            c_cpu += int'(cpu_clk_en);
            c_bus += int'(bus_clk_en);
            c_per += int'(per_clk_en);
            cyc();
        end
    endtask

    task automatic go_sleep(input logic deep);
        stby_sel = deep;
        sleep_req = 1'b1;
        cyc();
        sleep_req = 1'b0;
        stby_sel = 1'b0;
    endtask

    initial begin
        int c_cpu, c_bus, c_per, expr;
        string tg;

        cyc();
        do_reset();
        count64(c_cpu, c_bus, c_per);
        chk("R5 full rate cpu", c_cpu, 64);

        // R2 R3 R4: every code from every starting ratio
        for (int s0 = 0; s0 < 6; s0++) begin
            for (int sel = 0; sel < 8; sel++) begin
                do_reset();
                set_ratio(s0);
                chk("R2 start ratio", ratio_o, s0);
                wr_code(sel);
                cyc();
                cyc();
                chk("R2 no change before bus end", ratio_o, s0);
                chk("R2 mode before bus end", mode_o, run_mode(s0));
                end_bus();
                expr = (sel <= 5) ? sel : s0;
                tg = (sel > 5) ? "R4 reserved code" : ((sel == 0) ? "R3 back to full" : "R2 applied");
                chk(tg, ratio_o, expr);
                chk(tg, mode_o, run_mode(expr));
                count64(c_cpu, c_bus, c_per);
                chk("R5 cpu pulses", c_cpu, 64 >> expr);
                chk("R5 bus pulses", c_bus, 64 >> expr);
                chk("R5 per pulses", c_per, 64 >> expr);
            end
        end

        // R6 R7 R8 R9 at every ratio
        for (int r = 0; r < 6; r++) begin
            do_reset();
            set_ratio(r);
            go_sleep(1'b0);
            chk("R6 sleep mode", mode_o, 3);
            count64(c_cpu, c_bus, c_per);
            chk("R6 cpu gated", c_cpu, 0);
            chk("R6 bus runs", c_bus, 64 >> r);
            chk("R6 per runs", c_per, 64 >> r);
            if (r % 2 == 0) irq_int = 1'b1; else irq_ext = 1'b1;
            cyc();
            irq_int = 1'b0; irq_ext = 1'b0;
            chk("R7 wake mode", mode_o, run_mode(r));
            chk("R7 wake ratio", ratio_o, r);

            go_sleep(1'b1);
            chk("R8 standby mode", mode_o, 4);
            count64(c_cpu, c_bus, c_per);
            chk("R8 enables off", c_cpu + c_bus + c_per, 0);
            irq_int = 1'b1;
            cyc();
            irq_int = 1'b0;
            chk("R9 internal irq ignored", mode_o, 4);
            chk("R9 enables still off", {cpu_clk_en, bus_clk_en, per_clk_en}, 0);
            irq_ext = 1'b1;
            cyc();
            irq_ext = 1'b0;
            chk("R9 external wake mode", mode_o, run_mode(r));
            chk("R9 external wake ratio", ratio_o, r);
        end

        // R1 watchdog clears ratio and pending code
        do_reset();
        set_ratio(3);
        wr_code(1);
        wdt_ovf = 1'b1;
        cyc();
        wdt_ovf = 1'b0;
        chk("R1 wdt mode", mode_o, 0);
        chk("R1 wdt ratio", ratio_o, 0);
        cyc();
        chk("R1 wdt release", mode_o, 1);
        end_bus();
        chk("R1 pending discarded", ratio_o, 0);

        // R1 watchdog wins over a wake in the same cycle
        set_ratio(2);
        go_sleep(1'b0);
        irq_int = 1'b1; wdt_ovf = 1'b1;
        cyc();
        irq_int = 1'b0; wdt_ovf = 1'b0;
        chk("R1 wdt over wake", mode_o, 0);

        // R10 R11 from each mode
        for (int m = 0; m < 5; m++) begin
            do_reset();
            if (m >= 2) set_ratio(2);
            if (m == 3) go_sleep(1'b0);
            if (m == 4) go_sleep(1'b1);
            if (m == 0) res_n = 1'b0;
            cyc();
            hstby_n = 1'b0;
            cyc();
            chk("R10 hw standby mode", mode_o, 5);
            for (int i = 0; i < 8; i++) begin
                irq_ext = i[0];
                irq_int = i[1];
                cyc();
                chk("R10 enables off", {cpu_clk_en, bus_clk_en, per_clk_en}, 0);
                chk("R10 stays", mode_o, 5);
            end
            irq_ext = 1'b0; irq_int = 1'b0;
            res_n = 1'b1;
            hstby_n = 1'b1;
            cyc();
            chk("R11 exit via reset", mode_o, 0);
            cyc();
            chk("R11 then full rate", mode_o, 1);
            chk("R11 ratio cleared", ratio_o, 0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule